// File: doc/BRIEF.md
# Signed Integer Divider with Register Interface

This block divides signed two's-complement integers for a processor that reaches it through a simple register bus: one write strobe, a 3-bit word address, a write-data word and a combinational read-data word. Software loads a divisor, then supplies a dividend. Writing the dividend is itself the start command, so no separate go bit exists. Two dividend paths are provided. A double-width dividend is formed from a high word and a low word, and writing the low word starts a double-by-single division. A single-width dividend written through an alias address starts a single-by-single division. In that case the value is sign-extended internally, so both modes share one datapath.

The unit runs for a fixed number of clock cycles (39 by default). When the divisor is zero, or when the quotient cannot be represented in one signed word, it detects this in the first cycle of the operation and stops after a short fixed interval (6 cycles by default). On a normal finish the quotient replaces the low dividend word and the remainder replaces the high dividend word. On overflow the low word receives a saturated quotient and a sticky flag is raised. Software polls a busy bit in the status word to learn when results are ready.

Top module: `sdiv_mmio`

## Requirements
- R1: After reset, the busy bit, the overflow flag and every data register read as zero.
- R2: Address 0 holds the divisor and address 1 holds the high dividend word. Both read back the last value written to them.
- R3: A write to address 2 while idle stores the low dividend word and starts a signed division of the double-width value {high word, low word} by the divisor.
- R4: A write to address 3 while idle stores the value into the low dividend word and starts a signed division of that value, sign-extended, by the divisor. Reading address 3 returns the low dividend word.
- R5: On a normal finish, the low word holds the quotient truncated toward zero and the high word holds the remainder, which carries the sign of the dividend. This applies in both modes.
- R6: Without overflow, the busy bit stays high for exactly LAT cycles (default 39), counted from the clock edge that accepts the starting write.
- R7: Overflow occurs when the divisor is zero or when the true quotient lies outside the signed word range. On overflow, busy stays high for exactly OVF_LAT cycles (default 6), the overflow flag is set, and the low word receives the most positive value or the most negative value. The most negative value is chosen when the dividend and divisor signs differ. The high word is left unchanged.
- R8: The overflow flag stays set through later operations. Writing a status word with bit 1 = 0 clears it. Writing bit 1 = 1 leaves it unchanged.
- R9: While busy, writes to addresses 1, 2 and 3 are ignored and do not restart the operation. Reads of addresses 1 and 2 return the values those registers held when the operation began.
- R10: The status word at address 4 carries busy in bit 0 and the overflow flag in bit 1. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 3 | Word address of the access |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for bus_addr, combinational |
| busy_o | output | 1 | High while a division is in progress |

## Verification
A wrong quotient or remainder bit in the iterative datapath reaches the low and high words on the finishing edge. It can be read on the very next access. A misjudged overflow decision has a larger effect: it moves the end of busy from cycle 6 to cycle 39, or the reverse, and it replaces an exact quotient with a saturated one. A measured busy length therefore exposes it within one operation. A corrupted operand latch, or a start accepted while busy, shows up as a changed result or as a stretched busy interval for that same operation. The sweep covers every dividend and divisor of a 4-bit word configuration in both modes, so each of these faults produces a mismatch at the ports.

// File: rtl/sdiv_mmio.sv
module sdiv_mmio #(
  parameter int W       = 32,
  parameter int LAT     = 39,
  parameter int OVF_LAT = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic [2:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         busy_o
);

  localparam logic [2:0] A_DSR = 3'd0;
  localparam logic [2:0] A_HI  = 3'd1;
  localparam logic [2:0] A_LO  = 3'd2;
  localparam logic [2:0] A_AL  = 3'd3;
  localparam logic [2:0] A_ST  = 3'd4;
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] C_END  = CW'(LAT);
  localparam logic [CW-1:0] C_OVF  = CW'(OVF_LAT);
  localparam logic [CW-1:0] C_ITER = CW'(W);
  localparam logic [CW-1:0] C_ONE  = CW'(1);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]   dsr, hi, lo, magd, rem, q;
  logic [2*W-1:0] nmag;
  logic           busy, ovf_sts, ovf_q, nneg, dneg, dz;
  logic [CW-1:0]  cnt;

  wire wr_ok = bus_we && !busy;
  wire st64  = wr_ok && bus_addr == A_LO;
  wire st32  = wr_ok && bus_addr == A_AL;
  wire clr   = bus_we && bus_addr == A_ST && !bus_wdata[1];

  wire [2*W-1:0] n_in   = st32 ? {{W{bus_wdata[W-1]}}, bus_wdata} : {hi, bus_wdata};
  wire [2*W-1:0] nin_mg = n_in[2*W-1] ? -n_in : n_in;

  wire           qneg    = nneg ^ dneg;
  wire [2*W-1:0] lim_pos = {1'b0, magd, {(W-1){1'b0}}};
  wire [2*W-1:0] lim_neg = lim_pos + {{W{1'b0}}, magd};
  wire           ovf_now = dz || (qneg ? nmag >= lim_neg : nmag >= lim_pos);

  wire [W:0] trial = {rem, q[W-1]};
  wire [W:0] diff  = trial - {1'b0, magd};
  wire       take  = !diff[W];

  wire fin = busy && (cnt == C_END || (cnt == C_OVF && ovf_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsr <= '0; hi <= '0; lo <= '0; magd <= '0; rem <= '0; q <= '0;
      nmag <= '0; busy <= 1'b0; ovf_sts <= 1'b0; ovf_q <= 1'b0;
      nneg <= 1'b0; dneg <= 1'b0; dz <= 1'b0; cnt <= '0;
    end else begin
      if (bus_we && bus_addr == A_DSR) dsr <= bus_wdata;
      if (wr_ok && bus_addr == A_HI) hi <= bus_wdata;
      if (clr) ovf_sts <= 1'b0;
      if (st64 || st32) begin
        lo    <= bus_wdata;
        busy  <= 1'b1;
        cnt   <= C_ONE;
        nneg  <= n_in[2*W-1];
        dneg  <= dsr[W-1];
        magd  <= dsr[W-1] ? -dsr : dsr;
        dz    <= dsr == '0;
        nmag  <= nin_mg;
        rem   <= nin_mg[2*W-1:W];
        q     <= nin_mg[W-1:0];
        ovf_q <= 1'b0;
      end
      if (busy) begin
        cnt <= cnt + C_ONE;
        if (cnt == C_ONE) ovf_q <= ovf_now;
        if (cnt <= C_ITER) begin
          rem <= take ? diff[W-1:0] : trial[W-1:0];
          q   <= {q[W-2:0], take};
        end
      end
      if (fin) begin
        busy <= 1'b0;
        cnt  <= '0;
        if (ovf_q) begin
          lo      <= qneg ? SMIN : SMAX;
          ovf_sts <= 1'b1;
        end else begin
          lo <= qneg ? -q : q;
          hi <= nneg ? -rem : rem;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_DSR:       bus_rdata = dsr;
      A_HI:        bus_rdata = hi;
      A_LO, A_AL:  bus_rdata = lo;
      A_ST:        bus_rdata = {{(W-2){1'b0}}, ovf_sts, busy};
      default:     bus_rdata = '0;
    endcase
  end

  assign busy_o = busy;

  // R3 R4
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !busy && (bus_addr == A_LO || bus_addr == A_AL)) |=> (busy && cnt == C_ONE));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ovf_q && cnt != C_END) |=> busy);

  // R7
  early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ovf_q && cnt == C_OVF) |=> (!busy && ovf_sts && (lo == SMAX || lo == SMIN)));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sts && !clr) |=> ovf_sts);

  // R9
  operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(nmag));

  // R9
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> $stable(hi));

endmodule

// File: tb/sdiv_mmio_tb.sv
module sdiv_mmio_tb;
  localparam int W = 4, LAT = 39, OVF = 6;
  localparam int MAXV = (1 << (W-1)) - 1;
  localparam int MINV = -(1 << (W-1));

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [W-1:0] wd = '0;
  wire [W-1:0] rdat;
  wire busy;
  int total = 0, bad = 0, bcnt = 0;
  bit done = 0;

  sdiv_mmio #(.W(W), .LAT(LAT), .OVF_LAT(OVF)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wd), .bus_rdata(rdat), .busy_o(busy));

  always #4 clk = ~clk;
  always @(negedge clk) if (busy) bcnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
    addr = a; #1; v = rdat;
  endtask

  task automatic waitdone();
    for (int g = 0; g < 200 && busy; g++) @(negedge clk);
  endtask

  task automatic op(input bit m32, input int n, input int d, input logic [W-1:0] hpre);
    logic [W-1:0] vlo, vhi, vst, elo, ehi;
    int eq, er;
    bit ov;
    logic [2*W-1:0] nb;
    nb = n[2*W-1:0];
    wr(3'd0, d[W-1:0]);
    wr(3'd1, m32 ? hpre : nb[2*W-1:W]);
    bcnt = 0;
    wr(m32 ? 3'd3 : 3'd2, nb[W-1:0]);
    waitdone();
    ov = (d == 0);
    eq = 0; er = 0;
    if (!ov) begin
      eq = n / d; er = n % d;
      ov = (eq > MAXV) || (eq < MINV);
    end
    if (ov) begin
      eq = ((n < 0) != (d < 0)) ? MINV : MAXV;
      ehi = m32 ? hpre : nb[2*W-1:W];
    end else ehi = er[W-1:0];
    elo = eq[W-1:0];
    rd(3'd2, vlo); rd(3'd1, vhi); rd(3'd4, vst);
    if (ov) chk(bcnt == OVF, "R7 latency", bcnt, OVF);
    else    chk(bcnt == LAT, "R6 latency", bcnt, LAT);
    chk(vlo == elo, ov ? "R7 saturated low" : (m32 ? "R4 R5 quotient" : "R3 R5 quotient"), vlo, elo);
    chk(vhi == ehi, ov ? "R7 high kept" : "R5 remainder", vhi, ehi);
    chk(vst[1] == ov, "R7 flag", vst[1], ov);
    if (ov) wr(3'd4, '0);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R6 watchdog act=%0d exp=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd4, v); chk(v == '0, "R1 status", v, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    rd(3'd2, v); chk(v == '0, "R1 low", v, 0);

    wr(3'd0, 4'h9); rd(3'd0, v); chk(v == 4'h9, "R2 divisor", v, 9);
    wr(3'd1, 4'h6); rd(3'd1, v); chk(v == 4'h6, "R2 high", v, 6);

    // 21 / 5 = 4 rem 1, with ignored writes during the run
    wr(3'd0, 4'd5); wr(3'd1, 4'h1);
    bcnt = 0;
    wr(3'd2, 4'h5);
    rd(3'd4, v); chk(v == 4'h1, "R10 busy bit", v, 1);
    rd(3'd1, v); chk(v == 4'h1, "R9 high during run", v, 1);
    rd(3'd2, v); chk(v == 4'h5, "R9 low during run", v, 5);
    wr(3'd2, 4'hF); wr(3'd3, 4'h3); wr(3'd1, 4'h7);
    waitdone();
    chk(bcnt == LAT, "R9 no restart", bcnt, LAT);
    rd(3'd2, v); chk(v == 4'h4, "R9 quotient", v, 4);
    rd(3'd1, v); chk(v == 4'h1, "R9 remainder", v, 1);

    // alias: -6 / 3 = -2 rem 0
    wr(3'd0, 4'd3); wr(3'd1, 4'h9);
    bcnt = 0;
    wr(3'd3, 4'hA);
    rd(3'd2, v); chk(v == 4'hA, "R4 low mirrors alias", v, 10);
    rd(3'd3, v); chk(v == 4'hA, "R4 alias read", v, 10);
    waitdone();
    rd(3'd3, v); chk(v == 4'hE, "R4 quotient", v, 14);
    rd(3'd1, v); chk(v == 4'h0, "R4 remainder", v, 0);

    // sticky overflow
    wr(3'd0, 4'd0); wr(3'd2, 4'h1); waitdone();
    rd(3'd4, v); chk(v[1] == 1'b1, "R8 set", v[1], 1);
    wr(3'd0, 4'd1); wr(3'd1, 4'h0); wr(3'd2, 4'h3); waitdone();
    rd(3'd4, v); chk(v[1] == 1'b1, "R8 survives", v[1], 1);
    wr(3'd4, 4'hF); rd(3'd4, v); chk(v[1] == 1'b1, "R8 write one", v[1], 1);
    wr(3'd4, 4'h0); rd(3'd4, v); chk(v == 4'h0, "R8 cleared", v, 0);

    for (int n = MINV; n <= MAXV; n++)
      for (int d = MINV; d <= MAXV; d++)
        op(1'b1, n, d, 4'h5);
    for (int n = -(1 << (2*W-1)); n < (1 << (2*W-1)); n++)
      for (int d = MINV; d <= MAXV; d++)
        op(1'b0, n, d, 4'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule